// File: doc/BRIEF.md
# MDIO management engine

This block is an MDIO master for Clause-22 PHY management. Software first sets the MDC divisor code and the management-enable bit. It then writes one 32-bit maintenance word that carries the whole frame after the preamble: the start pattern, the opcode, the PHY address, the register address, the turnaround and 16 data bits.

The engine sends 32 preamble ones and then the word, most significant bit first. For a read it releases the pad for the turnaround and data bits and shifts in the 16 bits the PHY returns. When the frame ends, those 16 bits replace the low half of the maintenance register. Software learns that a frame has finished by polling the idle flag in the status word.

The register port has one address input. A write takes effect on the clock edge where `reg_wr` is high. Read data is combinational on the same address.

Top module: `mdio_mgmt_engine`

## Requirements
- R1: After reset, `mdc` is 0 and `mdio_oe` is 0. Control (address 0), config (address 1) and maintenance (address 3) read 0, and status (address 2) reads 0x4.
- R2: A started frame drives 64 bits on `mdio_o`. The first 32 are ones, followed by the maintenance word from bit 31 down to bit 0. Frame bit k is driven from MDC period k, and `mdio_o` only changes while `mdc` is low or at its falling edge.
- R3: The MDC period equals the divisor picked by config bits 20:18. Codes 0 to 7 give 8, 16, 32, 48, 64, 96, 128 and 224 host clocks. The high and low halves are equal, MDC starts low, and MDC is held low while idle.
- R4: If word bits 29:28 equal 10 (read), `mdio_oe` is 0 for frame bits 47 to 63. Otherwise `mdio_oe` is 1 for the whole frame.
- R5: During a read, `mdio_i` is sampled once for each of frame bits 48 to 63, just before the MDC rising edge, first bit to bit 15. At the end of the frame these 16 bits replace maintenance bits 15:0. Bits 31:16 are left unchanged.
- R6: Status bit 2 (idle) is 0 from the clock after an accepted start until 64 times the divisor host clocks later, and is 1 otherwise.
- R7: A frame starts only if control bit 4 is set. A maintenance write with bit 4 clear stores the word but starts no frame. Control bits 3 and 2 have no effect on MDC or MDIO.
- R8: A maintenance write while a frame is in flight is ignored. The stored word and the frame on the pad are unchanged.
- R9: Control and config read back exactly as written, and status reads 0 apart from bit 2.

Top module ports are listed below in port order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 config, 2 status, 3 maintenance |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO pad output value |
| mdio_oe | output | 1 | MDIO pad output enable |
| mdio_i | input | 1 | MDIO pad input value |

## Verification
The assertions rely on two assumptions about how software drives the block. First, the config divisor code does not change while a frame is in flight. Second, the PHY drives `mdio_i` only as a function of MDC edges. The stimulus writes the divisor code only while the engine is idle. The bench PHY changes its data bit only in the MDC-low phase, so the value is stable when it is sampled before each rising edge. One deliberate write lands mid-frame, to check that it is ignored.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int MDC_CNT_W   = 7;
  localparam int OP_HI       = 29;
  localparam int OP_LO       = 28;
  localparam logic [1:0] OP_READ = 2'b10;
  localparam int CODE_LO     = 18;
  localparam int MGMT_EN_BIT = 4;
  localparam int IDLE_BIT    = 2;

  typedef enum logic [1:0] {
    A_CTRL  = 2'd0,
    A_CFG   = 2'd1,
    A_STAT  = 2'd2,
    A_MAINT = 2'd3
  } reg_addr_e;

  // half of the MDC divisor, in host clocks
  function automatic logic [MDC_CNT_W-1:0] mdc_half(input logic [2:0] code);
    case (code)
      3'd0:    mdc_half = MDC_CNT_W'(4);
      3'd1:    mdc_half = MDC_CNT_W'(8);
      3'd2:    mdc_half = MDC_CNT_W'(16);
      3'd3:    mdc_half = MDC_CNT_W'(24);
      3'd4:    mdc_half = MDC_CNT_W'(32);
      3'd5:    mdc_half = MDC_CNT_W'(48);
      3'd6:    mdc_half = MDC_CNT_W'(64);
      default: mdc_half = MDC_CNT_W'(112);
    endcase
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
  import mdio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] code,
  output logic       mdc,
  output logic       rise_tick,
  output logic       fall_tick
);
  logic [MDC_CNT_W-1:0] cnt_q, cnt_d, half;
  logic                 mdc_q, mdc_d, term;

  assign half = mdc_half(code);
  assign term = run && (cnt_q == half - 1'b1);

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (term) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc       = mdc_q;
  assign rise_tick = term && !mdc_q;
  assign fall_tick = term && mdc_q;
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int WORD_W  = 32,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] word,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_i,
  output logic              busy,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              rd_done,
  output logic [DATA_W-1:0] rd_data
);
  localparam int FRAME_LEN = PRE_LEN + WORD_W;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int REL_IDX   = FRAME_LEN - DATA_W - 1;
  localparam int DAT_IDX   = REL_IDX + 1;
  localparam int LAST_IDX  = FRAME_LEN - 1;

  logic                 busy_q, busy_d, rd_op_q, rd_op_d, last_bit;
  logic [FRAME_LEN-1:0] sr_q, sr_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic [DATA_W-1:0]    cap_q, cap_d;

  assign last_bit = busy_q && fall_tick && (idx_q == IDX_W'(LAST_IDX));

  always_comb begin
    busy_d  = busy_q;
    rd_op_d = rd_op_q;
    sr_d    = sr_q;
    idx_d   = idx_q;
    cap_d   = cap_q;
    if (start && !busy_q) begin
      busy_d  = 1'b1;
      rd_op_d = (word[OP_HI:OP_LO] == OP_READ);
      sr_d    = {{PRE_LEN{1'b1}}, word};
      idx_d   = '0;
    end else if (busy_q) begin
      if (rise_tick && (idx_q >= IDX_W'(DAT_IDX)))
        cap_d = {cap_q[DATA_W-2:0], mdio_i};
      if (fall_tick) begin
        if (last_bit) begin
          busy_d = 1'b0;
        end else begin
          sr_d  = {sr_q[FRAME_LEN-2:0], 1'b1};
          idx_d = idx_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      rd_op_q <= 1'b0;
      sr_q    <= '0;
      idx_q   <= '0;
      cap_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      rd_op_q <= rd_op_d;
      sr_q    <= sr_d;
      idx_q   <= idx_d;
      cap_q   <= cap_d;
    end
  end

  assign busy    = busy_q;
  assign mdio_o  = sr_q[FRAME_LEN-1];
  assign mdio_oe = busy_q && !(rd_op_q && (idx_q >= IDX_W'(REL_IDX)));
  assign rd_done = last_bit && rd_op_q;
  assign rd_data = cap_q;
endmodule

// File: rtl/mdio_mgmt_engine.sv
module mdio_mgmt_engine
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int REG_W   = 32,
  parameter int DATA_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  logic [REG_W-1:0]  ctrl_q, ctrl_d, cfg_q, cfg_d, maint_q, maint_d;
  logic              busy, idle, mgmt_en, maint_wr, accept, start;
  logic              rise_tick, fall_tick, rd_done;
  logic [DATA_W-1:0] rd_data;

  assign idle     = !busy;
  assign mgmt_en  = ctrl_q[MGMT_EN_BIT];
  assign maint_wr = reg_wr && (reg_addr == A_MAINT);
  assign accept   = maint_wr && !busy;
  assign start    = accept && mgmt_en;

  always_comb begin
    ctrl_d  = (reg_wr && reg_addr == A_CTRL) ? reg_wdata : ctrl_q;
    cfg_d   = (reg_wr && reg_addr == A_CFG)  ? reg_wdata : cfg_q;
    maint_d = maint_q;
    if (accept)
      maint_d = reg_wdata;
    else if (rd_done)
      maint_d[DATA_W-1:0] = rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      cfg_q   <= '0;
      maint_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      cfg_q   <= cfg_d;
      maint_q <= maint_d;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = ctrl_q;
      A_CFG:   reg_rdata = cfg_q;
      A_STAT:  reg_rdata = REG_W'(idle) << IDLE_BIT;
      default: reg_rdata = maint_q;
    endcase
  end

  mdio_clkgen u_clk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy),
    .code      (cfg_q[CODE_LO+2:CODE_LO]),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_frame_seq #(
    .PRE_LEN (PRE_LEN),
    .WORD_W  (REG_W),
    .DATA_W  (DATA_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .word      (reg_wdata),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .mdio_i    (mdio_i),
    .busy      (busy),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .rd_done   (rd_done),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        idle,
  input logic        mgmt_en,
  input logic        maint_wr,
  input logic [31:0] maint_q
);
  AST_IDLE_PAD_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !mdio_oe);  // R1

  AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !mdc);  // R3

  AST_BIT_HOLD_MDC_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && mdc && $past(mdc)) |-> $stable(mdio_o));  // R2

  AST_RELEASE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && $fell(mdio_oe)) |-> (maint_q[29:28] == 2'b10));  // R4

  AST_START_CLEARS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && mgmt_en && maint_wr) |=> !idle);  // R6

  AST_DISABLED_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !mgmt_en) |=> idle);  // R7

  AST_BUSY_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && ($past(idle) == 1'b0)) |-> $stable(maint_q[31:16]));  // R8
endmodule

bind mdio_mgmt_engine mdio_mgmt_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mdc      (mdc),
  .mdio_o   (mdio_o),
  .mdio_oe  (mdio_oe),
  .idle     (idle),
  .mgmt_en  (mgmt_en),
  .maint_wr (maint_wr),
  .maint_q  (maint_q)
);

// File: tb/sim_mdio_mgmt_engine.sv
module sim_mdio_mgmt_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i;

  int n_chk = 0;
  int n_fail = 0;
  bit checking = 1'b0;

  // behavioural reference state
  bit          m_busy = 1'b0;
  int          t = 0;
  logic [31:0] m_word, m_maint, m_ctrl, m_cfg;
  logic [15:0] phy_val = 16'h0;

  always #4 clk = ~clk;

  mdio_mgmt_engine u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .mdio_i    (mdio_i)
  );

  function automatic int div_of(input logic [2:0] c);
    case (c)
      3'd0: return 8;
      3'd1: return 16;
      3'd2: return 32;
      3'd3: return 48;
      3'd4: return 64;
      3'd5: return 96;
      3'd6: return 128;
      default: return 224;
    endcase
  endfunction

  function automatic logic [31:0] frame(input logic [1:0] op, input int phy,
                                        input int rg, input logic [15:0] d);
    return {2'b01, op, 5'(phy), 5'(rg), 2'b10, d};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model update
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy  = 1'b0;
      t       = 0;
      m_word  = '0;
      m_maint = '0;
      m_ctrl  = '0;
      m_cfg   = '0;
    end else begin
      if (m_busy) begin
        if (t == 64 * div_of(m_cfg[20:18]) - 1) begin
          m_busy = 1'b0;
          if (m_word[29:28] == 2'b10) m_maint[15:0] = phy_val;
        end else begin
          t++;
        end
      end else if (reg_wr && reg_addr == 2'd3) begin
        m_maint = reg_wdata;
        if (m_ctrl[4]) begin
          m_busy = 1'b1;
          t      = 0;
          m_word = reg_wdata;
        end
      end
      if (reg_wr && reg_addr == 2'd0) m_ctrl = reg_wdata;
      if (reg_wr && reg_addr == 2'd1) m_cfg  = reg_wdata;
    end
  end

  // per-cycle comparison and PHY behaviour, away from the active edge
  always @(negedge clk) begin
    logic [31:0] exp_rd;
    mdio_i = 1'b1;
    if (rst_n && checking) begin
      if (m_busy) begin
        int d, idx;
        bit rd, e_oe, e_bit;
        d     = div_of(m_cfg[20:18]);
        idx   = t / d;
        rd    = (m_word[29:28] == 2'b10);
        e_oe  = !(rd && idx >= 47);
        e_bit = (idx < 32) ? 1'b1 : m_word[63 - idx];
        chk("R3 mdc", {31'b0, mdc}, {31'b0, 1'(((t / (d / 2)) % 2))});
        chk("R4 mdio_oe", {31'b0, mdio_oe}, {31'b0, e_oe});
        if (e_oe) chk("R2 mdio_o", {31'b0, mdio_o}, {31'b0, e_bit});
        if (rd && idx >= 48) mdio_i = phy_val[63 - idx];
      end else begin
        chk("R3 mdc idle", {31'b0, mdc}, 32'h0);
        chk("R1 mdio_oe idle", {31'b0, mdio_oe}, 32'h0);
      end
      case (reg_addr)
        2'd0: exp_rd = m_ctrl;
        2'd1: exp_rd = m_cfg;
        2'd2: exp_rd = {29'b0, !m_busy, 2'b0};
        default: exp_rd = m_maint;
      endcase
      if (reg_addr == 2'd2)      chk("R6 status", reg_rdata, exp_rd);
      else if (reg_addr == 2'd3) chk("R5 maint", reg_rdata, exp_rd);
      else                       chk("R9 readback", reg_rdata, exp_rd);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_addr = 2'd2;
  endtask

  task automatic rdchk(input logic [1:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    chk(tag, reg_rdata, exp);
    @(posedge clk); #1;
    reg_addr = 2'd2;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_busy) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] w;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 2'd2; reg_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset status", reg_rdata, 32'h4);
    chk("R1 reset mdc", {31'b0, mdc}, 32'h0);
    chk("R1 reset oe", {31'b0, mdio_oe}, 32'h0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    rdchk(2'd0, 32'h0, "R1 reset ctrl");
    rdchk(2'd1, 32'h0, "R1 reset cfg");
    rdchk(2'd3, 32'h0, "R1 reset maint");
    checking = 1'b1;

    wr(2'd0, 32'h0000_0010);
    for (int c = 0; c < 8; c++) begin
      wr(2'd1, 32'(c) << 18);
      if (c % 2 == 0) begin
        w = frame(2'b01, c + 1, c + 3, 16'hA5C3 ^ 16'(c));
        wr(2'd3, w);
        wait_idle();
        rdchk(2'd3, w, "R2 write frame word kept");
      end else begin
        phy_val = 16'h1234 * 16'(c + 1);
        w = frame(2'b10, 31 - c, c, 16'h0);
        wr(2'd3, w);
        wait_idle();
        rdchk(2'd3, {w[31:16], phy_val}, "R5 read result");
      end
      rdchk(2'd2, 32'h4, "R6 idle after frame");
    end

    // R8: write during a read frame is ignored
    wr(2'd1, 32'(1) << 18);
    phy_val = 16'hBEEF;
    w = frame(2'b10, 5, 9, 16'h0);
    wr(2'd3, w);
    repeat (100) @(posedge clk);
    wr(2'd3, frame(2'b01, 20, 21, 16'h5555));
    wait_idle();
    rdchk(2'd3, {w[31:16], 16'hBEEF}, "R8 busy write ignored");

    // R7: enable clear, only rx/tx bits set
    wr(2'd0, 32'h0000_000C);
    rdchk(2'd0, 32'h0000_000C, "R9 ctrl readback");
    w = frame(2'b01, 3, 4, 16'h0F0F);
    wr(2'd3, w);
    repeat (40) @(posedge clk);
    rdchk(2'd2, 32'h4, "R7 no frame when disabled");
    rdchk(2'd3, w, "R7 word stored");

    // re-enable with rx/tx bits also set
    wr(2'd0, 32'h0000_001C);
    wr(2'd1, 32'hFFE3_FFFF & (32'h0 | (32'd0 << 18)) | 32'h0000_0001);
    rdchk(2'd1, 32'h0000_0001, "R9 cfg readback");
    w = frame(2'b01, 0, 31, 16'h8001);
    wr(2'd3, w);
    wait_idle();
    rdchk(2'd3, w, "R7 frame after enable");

    checking = 1'b0;
    finish_run();
  end
endmodule